// File: doc/BRIEF.md
# Carrier Detect Qualifier

This block turns a raw tone-present flag from an FSK discriminator into a qualified, active-low carrier indication. It only declares carrier after tone has been present without a break for a fixed dwell. Once carrier is declared, it only withdraws it after tone has been absent for a shorter dwell, so short gaps in the tone do not make the output toggle. Both dwells are counted in half-millisecond ticks taken from the master clock through a prescaler.

The qualified state also gates the demodulated serial data on its way out. The data line reads high until carrier has been declared. A power-down input forces the block idle, drops any partial dwell count, and holds both outputs high.

With the default parameters and a 3.579545 MHz clock, the prescaler divides by 1790 to give a 0.5 ms tick. Acquisition takes 30 ticks (15 ms), which is within the 25 ms limit. Release takes 19 ticks (9.5 ms), which is inside the 8 to 11 ms window.

Top module: `carrier_qualifier`

## Requirements
- R1: After reset, `cd_n` is 1 and `ser_out` is 1.
- R2: With `tone_present` held at 1 starting in cycle c, `cd_n` is still 1 at cycle c+(ACQ_TICKS-1)*TICK_DIV. It is 0 (carrier active, active low) by cycle c+ACQ_TICKS*TICK_DIV. `cd_n` only falls on a tick edge at which tone was present.
- R3: A single cycle with `tone_present` at 0 during acquisition discards the dwell collected so far. Acquisition then needs the full window again, counted from the cycle in which tone returns.
- R4: While carrier is active, with `tone_present` held at 0 starting in cycle c, `cd_n` is still 0 at cycle c+(REL_TICKS-1)*TICK_DIV. It is 1 by cycle c+REL_TICKS*TICK_DIV.
- R5: A tone dropout no longer than (REL_TICKS-1)*TICK_DIV cycles leaves `cd_n` at 0. Any cycle with tone present during the release countdown restarts that countdown from zero.
- R6: While `cd_n` is 1, `ser_out` is 1 whatever the value of `ser_in`. While `cd_n` is 0, `ser_out` equals `ser_in` in the same cycle.
- R7: `pwr_down` at 1 drives `cd_n` to 1 at the next clock edge and forces `ser_out` to 1 at once. While `pwr_down` stays at 1, `tone_present` has no effect.
- R8: When `pwr_down` returns to 0, acquisition starts from zero. A partial dwell collected before power-down does not shorten the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Synchronous power-down; clears all timing state |
| tone_present | input | 1 | Per-cycle tone flag from the discriminator |
| ser_in | input | 1 | Demodulated serial data |
| cd_n | output | 1 | Qualified carrier, 0 when carrier is active |
| ser_out | output | 1 | Serial data, held at 1 while carrier is inactive |

## Verification
Acquisition is driven with three tone patterns: an unbroken tone, a tone broken by a one-cycle gap just before the window closes, and a tone cut off by a short power-down pulse. Together these separate a true continuous-dwell counter from one that accumulates ticks or keeps state across power-down. Release is driven with a long silence, and with a dropout that ends just inside the window and is followed by a second silence. The second case shows whether the countdown truly restarts. Each window is checked at both edges: still inactive one tick early, and active by the final tick. This catches off-by-one-tick errors for any tick phase. Serial data is toggled in both carrier states, which exposes a missing gate or an inverted gate.

// File: rtl/cdq_pkg.sv
package cdq_pkg;

  typedef enum logic {
    CDQ_IDLE   = 1'b0,
    CDQ_LOCKED = 1'b1
  } cdq_state_e;

endpackage

// File: rtl/cdq_tick_gen.sv
module cdq_tick_gen #(
  parameter int unsigned TICK_DIV = 1790
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);

  localparam int unsigned CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/cdq_dwell_cnt.sv
module cdq_dwell_cnt #(
  parameter int unsigned LIMIT = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic done
);

  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done = !clr && step && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (done) cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  dwell_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cnt_q == '0));

endmodule

// File: rtl/carrier_qualifier.sv
module carrier_qualifier #(
  parameter int unsigned TICK_DIV  = 1790,
  parameter int unsigned ACQ_TICKS = 30,
  parameter int unsigned REL_TICKS = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  input  logic tone_present,
  input  logic ser_in,
  output logic cd_n,
  output logic ser_out
);
  import cdq_pkg::*;

  cdq_state_e state_q, state_d;
  logic       tick;
  logic       locked;
  logic       acq_clr, rel_clr;
  logic       acq_done, rel_done;

  assign locked = (state_q == CDQ_LOCKED);

  cdq_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (pwr_down),
    .tick  (tick)
  );

  assign acq_clr = pwr_down || locked || !tone_present;
  assign rel_clr = pwr_down || !locked || tone_present;

  cdq_dwell_cnt #(.LIMIT(ACQ_TICKS)) u_acq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (acq_clr),
    .step  (tick),
    .done  (acq_done)
  );

  cdq_dwell_cnt #(.LIMIT(REL_TICKS)) u_rel (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rel_clr),
    .step  (tick),
    .done  (rel_done)
  );

  always_comb begin
    state_d = state_q;
    if (pwr_down)                 state_d = CDQ_IDLE;
    else if (!locked && acq_done) state_d = CDQ_LOCKED;
    else if (locked && rel_done)  state_d = CDQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CDQ_IDLE;
    else        state_q <= state_d;
  end

  assign cd_n    = !locked;
  assign ser_out = (locked && !pwr_down) ? ser_in : 1'b1;

  // R7
  pdn_forces_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> cd_n);

  // R6
  ser_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cd_n |-> ser_out);

  // R2
  lock_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cd_n) |-> ($past(tick) && $past(tone_present) && !$past(pwr_down)));

  // R4
  release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cd_n) |-> ($past(pwr_down) || ($past(tick) && !$past(tone_present))));

endmodule

// File: tb/carrier_qualifier_tb.sv
module carrier_qualifier_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;
  localparam int ACQ = 30;
  localparam int REL = 19;
  localparam int WATCHDOG = 100000;

  logic clk, rst_n, pwr_down, tone_present, ser_in;
  logic cd_n, ser_out;

  typedef struct {
    int    cyc;
    logic  exp_cd;
    logic  exp_ser;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int   cyc;
  int   n_checks;
  int   n_errors;
  bit   done_flag;

  carrier_qualifier #(.TICK_DIV(DIV), .ACQ_TICKS(ACQ), .REL_TICKS(REL)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_down     (pwr_down),
    .tone_present (tone_present),
    .ser_in       (ser_in),
    .cd_n         (cd_n),
    .ser_out      (ser_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares queued expectations at the falling edge.
  initial begin
    n_checks = 0;
    n_errors = 0;
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (cd_n !== e.exp_cd || ser_out !== e.exp_ser) begin
          n_errors++;
          $display("FAIL %s at cycle %0d: cd_n=%b ser_out=%b expected cd_n=%b ser_out=%b",
                   e.tag, cyc, cd_n, ser_out, e.exp_cd, e.exp_ser);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) step();
  endtask

  task automatic expect_at(input int t, input logic ecd, input logic eser, input string tag);
    exp_t e;
    e.cyc = t; e.exp_cd = ecd; e.exp_ser = eser; e.tag = tag;
    sb_q.push_back(e);
  endtask

  initial begin
    int c, c2, c3;
    done_flag = 0;
    rst_n = 1'b0; pwr_down = 1'b0; tone_present = 1'b0; ser_in = 1'b1;
    repeat (5) step();
    rst_n = 1'b1;
    step();
    expect_at(cyc + 1, 1'b1, 1'b1, "R1 reset state");
    step(); step();
    ser_in = 1'b0;
    expect_at(cyc + 1, 1'b1, 1'b1, "R6 data gated while idle");
    step(); step();

    // R2: continuous tone acquires in the window
    tone_present = 1'b1; c = cyc;
    expect_at(c + (ACQ-1)*DIV, 1'b1, 1'b1, "R2 not yet locked");
    expect_at(c + ACQ*DIV, 1'b0, 1'b0, "R2 locked");
    wait_until(c + ACQ*DIV + 1);

    // R6: data passes while locked
    ser_in = 1'b1;
    expect_at(cyc + 1, 1'b0, 1'b1, "R6 pass high");
    step();
    ser_in = 1'b0;
    expect_at(cyc + 1, 1'b0, 1'b0, "R6 pass low");
    step(); step();

    // R4: long silence releases
    tone_present = 1'b0; c = cyc;
    expect_at(c + (REL-1)*DIV, 1'b0, 1'b0, "R4 still locked");
    expect_at(c + REL*DIV, 1'b1, 1'b1, "R4 released");
    wait_until(c + REL*DIV + 1);

    // R3: one-cycle gap restarts acquisition
    tone_present = 1'b1; c = cyc;
    wait_until(c + (ACQ-1)*DIV - 2);
    tone_present = 1'b0;
    step();
    tone_present = 1'b1; c2 = cyc;
    expect_at(c2 + (ACQ-1)*DIV, 1'b1, 1'b1, "R3 gap restarted dwell");
    expect_at(c2 + ACQ*DIV, 1'b0, 1'b0, "R3 locked after full dwell");
    wait_until(c2 + ACQ*DIV + 1);

    // R5: short dropout holds, tone restarts countdown
    tone_present = 1'b0; c = cyc;
    expect_at(c + (REL-1)*DIV - 2, 1'b0, 1'b0, "R5 dropout held");
    wait_until(c + (REL-1)*DIV - 2);
    tone_present = 1'b1;
    repeat (3) step();
    tone_present = 1'b0; c3 = cyc;
    expect_at(c3 + (REL-1)*DIV, 1'b0, 1'b0, "R5 countdown restarted");
    expect_at(c3 + REL*DIV, 1'b1, 1'b1, "R5 release after restart");
    wait_until(c3 + REL*DIV + 1);

    // R8: partial dwell dropped by power-down pulse
    tone_present = 1'b1; c = cyc;
    wait_until(c + (ACQ-1)*DIV - 2);
    pwr_down = 1'b1;
    repeat (3) step();
    pwr_down = 1'b0; c2 = cyc;
    expect_at(c2 + (ACQ-1)*DIV, 1'b1, 1'b1, "R8 dwell restarted after power-down");
    expect_at(c2 + ACQ*DIV, 1'b0, 1'b0, "R8 locked after full dwell");
    wait_until(c2 + ACQ*DIV + 1);

    // R7: power-down while locked, tone ignored
    pwr_down = 1'b1; c = cyc;
    expect_at(c + 1, 1'b1, 1'b1, "R7 forced idle");
    expect_at(c + ACQ*DIV + 5, 1'b1, 1'b1, "R7 tone ignored in power-down");
    wait_until(c + ACQ*DIV + 6);
    ser_in = 1'b0;
    expect_at(cyc + 1, 1'b1, 1'b1, "R7 data held high");
    step(); step();
    pwr_down = 1'b0; c2 = cyc;
    expect_at(c2 + ACQ*DIV, 1'b0, 1'b0, "R8 relock after power-down");
    wait_until(c2 + ACQ*DIV + 2);

    while (sb_q.size() > 0) step();
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done_flag) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule